// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory holding 4096 bytes. It runs from a fast system clock, samples the serial clock and data lines through two-flop synchronizers, and finds bus edges, Start conditions and Stop conditions on those synchronized samples. It answers only to a device byte whose upper nibble is `1010` and whose next three bits match its strap pins. The lowest bit of that byte chooses the direction.

A write transfer carries two word-address bytes and then any number of data bytes. Each data byte goes into the storage array, which is modelled as a plain RAM. The address advances inside a 32-byte page and wraps within that page. A Stop that follows written data starts a self-timed programming window of `WR_CYCLES` clocks. During that window the engine does not acknowledge its own device byte, so a host can poll with a write header until it gets an ACK.

Reads start at the internal address counter. A current-address read uses the counter as it stands. A random read first loads the counter with a header-only write and then issues a repeated Start. Every master ACK moves the read to the next byte, and at the top of the array the address wraps to 0. The data line is never driven high: `sda_pull_low` only asks the pad to pull the line low.

Top module: `twowire_mem_slave`

## Requirements
- R1: The device byte is acknowledged only when bits 7..4 equal `1010` and bits 3..1 equal `dev_sel`. Bit 0 set to 1 selects a read and bit 0 cleared selects a write. A byte that does not match gets no ACK, and the engine stays silent until the next Start.
- R2: A Start is the data line falling while the clock line is high, and a Stop is the data line rising while the clock line is high. The engine changes its data drive only while the clock line is low.
- R3: After every byte it accepts, the engine holds the data line low throughout the high phase of the ninth clock.
- R4: A Stop that follows at least one written data byte raises `busy` for exactly `WR_CYCLES` clocks. While `busy` is high, the engine does not acknowledge its device byte. Once `busy` is low, the same header is acknowledged again.
- R5: The word address is 12 bits. It is made of bits 3..0 of the first address byte followed by all of the second byte, and bits 7..4 of the first byte are ignored.
- R6: Each written data byte goes to the current address. The address then advances in its low 5 bits only, so a write past the end of a 32-byte page continues at the start of that same page.
- R7: A current-address read returns the byte after the last one accessed. Address 4095 is followed by address 0.
- R8: A write header plus two address bytes, followed by a repeated Start and a read header, returns data starting at the loaded address.
- R9: During a read, each master ACK delivers the next byte, and the address wraps from 4095 to 0.
- R10: A master NoAck after a read byte ends the transfer. The engine releases the data line and stays released until the next Start.
- R11: A Start at any point abandons the current byte and makes the engine expect a device byte. A partly received address byte changes nothing.
- R12: After reset, `busy` is low, the data line is released and the engine waits for a Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired value) |
| dev_sel | input | 3 | Strap pins matched against device-byte bits 3..1 |
| sda_pull_low | output | 1 | 1 = pull the data line low, 0 = release it |
| busy | output | 1 | High during the self-timed programming window |

## Verification
A change on either bus line reaches the synchronized samples two clocks later, and the engine acts on the third rising clock. The ACK and read data are therefore in place well inside each half-period of 8 clocks. The bench samples the data line in the middle of each clock-high phase, four clocks after the rising edge, so every sample falls after that latency. `busy` must rise on the third rising clock after the data line goes high at a Stop that follows written data. The bench's reference counter starts on exactly that edge and is compared with `busy` on every falling clock edge, so a window one cycle too early, too late, too long or too short is caught.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  output logic       sda_pull_low,
  output logic       busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_AHI, S_AHI_ACK, S_ALO, S_ALO_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK, S_WAIT
  } st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  st_t                st;
  logic [3:0]         cnt;
  logic [7:0]         sr, tx;
  logic [HI_W-1:0]    hi_q;
  logic [ADDR_W-1:0]  ptr;
  logic               rnw, wrote;
  logic [CW-1:0]      busy_cnt;
  logic [7:0]         mem [DEPTH];
  logic [PAGE_W-1:0]  lo_inc;

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign lo_inc    = ptr[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
  assign busy      = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (stop_det && wrote)
      busy_cnt <= CW'(WR_CYCLES);
    else if (busy_cnt != '0)
      busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st == S_WR && scl_fall && cnt == 4'd8)
      mem[ptr] <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      sr           <= '0;
      tx           <= '0;
      hi_q         <= '0;
      ptr          <= '0;
      rnw          <= 1'b0;
      wrote        <= 1'b0;
      sda_pull_low <= 1'b0;
    end else if (start_det) begin
      st           <= S_DEV;
      cnt          <= '0;
      sda_pull_low <= 1'b0;
    end else if (stop_det) begin
      st           <= S_IDLE;
      cnt          <= '0;
      wrote        <= 1'b0;
      sda_pull_low <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO, S_WR: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            case (st)
              S_DEV: begin
                if (sr[7:4] == 4'b1010 && sr[3:1] == dev_sel && !busy) begin
                  rnw          <= sr[0];
                  sda_pull_low <= 1'b1;
                  st           <= S_DEV_ACK;
                end else begin
                  st <= S_WAIT;
                end
              end
              S_AHI: begin
                hi_q         <= sr[HI_W-1:0];
                sda_pull_low <= 1'b1;
                st           <= S_AHI_ACK;
              end
              S_ALO: begin
                ptr          <= {hi_q, sr};
                sda_pull_low <= 1'b1;
                st           <= S_ALO_ACK;
              end
              default: begin
                ptr          <= {ptr[ADDR_W-1:PAGE_W], lo_inc};
                wrote        <= 1'b1;
                sda_pull_low <= 1'b1;
                st           <= S_WR_ACK;
              end
            endcase
          end
        end
        S_DEV_ACK: begin
          if (scl_fall) begin
            if (rnw) begin
              tx           <= mem[ptr];
              sda_pull_low <= ~mem[ptr][7];
              ptr          <= ptr + 1'b1;
              cnt          <= 4'd1;
              st           <= S_RD;
            end else begin
              sda_pull_low <= 1'b0;
              st           <= S_AHI;
            end
          end
        end
        S_AHI_ACK: if (scl_fall) begin sda_pull_low <= 1'b0; st <= S_ALO; end
        S_ALO_ACK: if (scl_fall) begin sda_pull_low <= 1'b0; st <= S_WR; end
        S_WR_ACK:  if (scl_fall) begin sda_pull_low <= 1'b0; st <= S_WR; end
        S_RD: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull_low <= 1'b0;
              cnt          <= '0;
              st           <= S_RD_ACK;
            end else begin
              sda_pull_low <= ~tx[6];
              tx           <= {tx[6:0], 1'b0};
              cnt          <= cnt + 1'b1;
            end
          end
        end
        S_RD_ACK: begin
          if (scl_rise && sda_s) begin
            st <= S_WAIT;
          end else if (scl_fall) begin
            tx           <= mem[ptr];
            sda_pull_low <= ~mem[ptr][7];
            ptr          <= ptr + 1'b1;
            cnt          <= 4'd1;
            st           <= S_RD;
          end
        end
        default: ;
      endcase
    end
  end

  p_oe_rise_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> !$past(scl_s));

  p_busy_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV && scl_fall && cnt == 4'd8 && busy) |=> !sda_pull_low);

  p_stop_starts_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && wrote) |=> busy);

  p_start_resets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_DEV && !sda_pull_low && cnt == 4'd0));

  p_read_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD_ACK && scl_fall && ptr == '1) |=> (ptr == '0));

  p_nack_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_pull_low);
endmodule

// File: tb/twowire_mem_slave_bench.sv
module twowire_mem_slave_bench;
  localparam int H   = 8;
  localparam int WRC = 400;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_low, busy;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_low;

  twowire_mem_slave #(.ADDR_W(12), .PAGE_W(5), .WR_CYCLES(WRC)) u_twowire_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel(PINS), .sda_pull_low(sda_pull_low), .busy(busy)
  );

  int tests = 0;
  int fails = 0;
  int left = 0;
  bit wr_pend = 1'b0;
  bit done = 1'b0;
  logic [7:0] ref_mem [4096];
  int ref_ptr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) chk(busy == (left > 0), "R4 busy window", busy, left > 0);
    if (left > 0) left--;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1;
    if (wr_pend) begin
      repeat (3) @(posedge clk);
      left = WRC;
      wr_pend = 1'b0;
    end
    tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(H);
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H / 2);
    ack = !sda_line;
    tick(H / 2);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1; tick(H / 2);
      b[i] = sda_line;
      tick(H / 2);
      scl_m = 1'b0;
    end
    tick(H);
    sda_m = !mack; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic rd_seq(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, b);
      chk(b === ref_mem[ref_ptr], req, b, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 4096;
    end
    chk(sda_pull_low == 1'b0, "R10 released after NoAck", sda_pull_low, 0);
    tick(2 * H);
    chk(sda_pull_low == 1'b0, "R10 stays released", sda_pull_low, 0);
  endtask

  task automatic set_addr(input int a);
    bit ack;
    wbyte({4'b1010, PINS, 1'b0}, ack);
    chk(ack, "R1 write header", ack, 1);
    wbyte({4'hA, 4'(a >> 8)}, ack);
    chk(ack, "R5 high address ACK", ack, 1);
    wbyte(8'(a), ack);
    chk(ack, "R3 low address ACK", ack, 1);
    ref_ptr = a;
  endtask

  task automatic wr_txn(input int a, input int n, input int seed);
    bit ack;
    logic [7:0] d;
    int p;
    bus_start();
    set_addr(a);
    p = a;
    for (int k = 0; k < n; k++) begin
      d = 8'(seed + k * 37);
      wbyte(d, ack);
      chk(ack, "R6 data ACK", ack, 1);
      ref_mem[p] = d;
      p = (p & 12'hFE0) | ((p + 1) & 31);
      wr_pend = 1'b1;
    end
    ref_ptr = p;
    bus_stop();
  endtask

  task automatic rnd_rd(input int a, input int n, input string req);
    bit ack;
    bus_start();
    set_addr(a);
    bus_start();
    wbyte({4'b1010, PINS, 1'b1}, ack);
    chk(ack, "R8 read header", ack, 1);
    rd_seq(n, req);
    bus_stop();
  endtask

  task automatic cur_rd(input int n, input string req);
    bit ack;
    bus_start();
    wbyte({4'b1010, PINS, 1'b1}, ack);
    chk(ack, "R7 read header", ack, 1);
    rd_seq(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    chk(sda_pull_low == 1'b0, "R12 reset drive", sda_pull_low, 0);
    chk(busy == 1'b0, "R12 reset busy", busy, 0);

    bus_start();
    wbyte({4'b1010, ~PINS, 1'b0}, ack);
    chk(!ack, "R1 pin mismatch", ack, 0);
    bus_stop();
    bus_start();
    wbyte({4'b1011, PINS, 1'b0}, ack);
    chk(!ack, "R1 type mismatch", ack, 0);
    bus_stop();

    wr_txn(12'h123, 1, 8'h5C);
    bus_start();
    wbyte({4'b1010, PINS, 1'b0}, ack);
    chk(!ack, "R4 poll while busy", ack, 0);
    bus_stop();
    tick(WRC);
    bus_start();
    wbyte({4'b1010, PINS, 1'b0}, ack);
    chk(ack, "R4 poll after window", ack, 1);
    bus_stop();

    rnd_rd(12'h123, 1, "R8 random read");

    wr_txn(12'h3FC, 6, 8'h11);
    tick(WRC + 10);
    rnd_rd(12'h3FC, 1, "R8 page start");
    cur_rd(3, "R7 current read");
    rnd_rd(12'h3E0, 2, "R6 page wrap");

    wr_txn(12'hFFF, 1, 8'hA7);
    tick(WRC + 10);
    wr_txn(12'h000, 1, 8'h3B);
    tick(WRC + 10);
    rnd_rd(12'hFFF, 2, "R9 array wrap");
    rnd_rd(12'hFFF, 1, "R9 top byte");
    cur_rd(1, "R7 wrap to zero");

    bus_start();
    wbyte({4'b1010, PINS, 1'b0}, ack);
    wbyte(8'h03, ack);
    send_bits(8'hE0, 3);
    bus_start();
    set_addr(12'h123);
    bus_start();
    wbyte({4'b1010, PINS, 1'b1}, ack);
    chk(ack, "R11 header after restart", ack, 1);
    rd_seq(1, "R11 partial byte dropped");
    bus_stop();

    tick(20);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule